// File: doc/BRIEF.md
# Variable-Block Carry-Skip Adder

This block is a purely combinational adder for two W-bit unsigned operands and a carry-in. It produces a W-bit sum and a carry-out. The bit range is cut into consecutive blocks, and the blocks do not all have to be the same width. Inside a block, the carry moves from bit to bit through a plain ripple chain.

Each block also ANDs together the per-bit propagate terms. When that product is true, the carry arriving at the block is forwarded straight to the block's outgoing carry. The block widths come from a parameter table, and elaboration stops with an error if the widths do not add up to W.

The block is instantiated wherever an unpipelined add is needed. It has no clock and no state, so the result follows the inputs after the logic delay.

Top module: `vbskip_adder`

## Requirements
- R1: `sum` equals the low W bits of a + b + cin, where all three are treated as unsigned.
- R2: `cout` equals bit W of a + b + cin.
- R3: With the default size table {2,4,5,6,6,5,4}, counted from bit 0 upward, the blocks start at bits 0, 2, 6, 11, 17, 23 and 28. The carry into each of these boundaries equals the arithmetic carry out of the lower bits. A carry that ripples exactly up to a boundary therefore shows up in the sum bit at that boundary.
- R4: When every bit of a differs from the corresponding bit of b, the carry-in is forwarded unchanged to `cout`, and every sum bit equals the inverse of cin.
- R5: When both operands are zero, `sum` equals cin in bit 0 and zeros elsewhere, and `cout` is 0.
- R6: When both operands are all ones, `cout` is 1 and `sum` is all ones except bit 0, which equals cin.
- R7: Results are correct for alternating-bit operands (0x5555_5555 with 0xAAAA_AAAA, and each pattern added to itself) at both values of cin.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | W | First operand |
| b | input | W | Second operand |
| cin | input | 1 | Carry into bit 0 |
| sum | output | W | Sum bits |
| cout | output | 1 | Carry out of bit W-1 |

## Verification
The assertions assume that a, b and cin are two-state and stable while they are evaluated. This holds because the bench drives them on a clock edge and reads results only at the opposite edge. The block-carry assertion also assumes the default size table, since it recomputes the boundaries from the same parameter. The stimulus keeps to this by driving only known values: corners, alternating patterns, carries aimed at each boundary, and random words drawn from a seeded generator.

// File: rtl/vbskip_adder.sv
module vbskip_adder #(
  parameter int W = 32,
  parameter int NBLK = 7,
  parameter int BLK_SZ [NBLK] = '{2, 4, 5, 6, 6, 5, 4}
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         cout
);

  function automatic int size_total();
    int s = 0;
    for (int j = 0; j < NBLK; j++) s += BLK_SZ[j];
    return s;
  endfunction

  function automatic int blk_base(int k);
    int s = 0;
    for (int j = 0; j < k; j++) s += BLK_SZ[j];
    return s;
  endfunction

  if (size_total() != W) begin : g_bad_total
    $error("block size table sums to %0d, expected %0d", size_total(), W);
  end

  logic [W-1:0]  p;
  logic [W-1:0]  g;
  logic [NBLK:0] bc;

  assign p     = a ^ b;
  assign g     = a & b;
  assign bc[0] = cin;
  assign cout  = bc[NBLK];

  for (genvar k = 0; k < NBLK; k++) begin : g_blk
    localparam int BASE = blk_base(k);
    localparam int SZ   = BLK_SZ[k];

    if (SZ < 1) begin : g_bad_size
      $error("block %0d has zero width", k);
    end

    logic [SZ:0] rip;
    logic        skip;

    assign rip[0] = bc[k];
    assign skip   = &p[BASE +: SZ];

    for (genvar i = 0; i < SZ; i++) begin : g_bit
      assign rip[i+1]       = g[BASE+i] | (p[BASE+i] & rip[i]);
      assign sum[BASE+i]    = p[BASE+i] ^ rip[i];
    end

    assign bc[k+1] = rip[SZ] | (skip & bc[k]);
  end

endmodule

// File: rtl/vbskip_adder_chk.sv
module vbskip_adder_chk #(
  parameter int W = 32,
  parameter int NBLK = 7,
  parameter int BLK_SZ [NBLK] = '{2, 4, 5, 6, 6, 5, 4}
) (
  input logic [W-1:0] a,
  input logic [W-1:0] b,
  input logic         cin,
  input logic [W-1:0] sum,
  input logic         cout,
  input logic [NBLK:0] bc
);

  logic [W:0] full;
  assign full = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin};

  always_comb begin
    p_sum_exact_r1: assert (sum == full[W-1:0])
      else $error("R1 sum mismatch");
    p_carry_out_r2: assert (cout == full[W])
      else $error("R2 carry-out mismatch");
    if ((a ^ b) == {W{1'b1}}) begin
      p_skip_pass_r4: assert (cout == cin && sum == {W{~cin}})
        else $error("R4 skip path mismatch");
    end
    if (a == '0 && b == '0) begin
      p_zero_ops_r5: assert (!cout && sum == {{(W-1){1'b0}}, cin})
        else $error("R5 zero operands mismatch");
    end
    if (a == {W{1'b1}} && b == {W{1'b1}}) begin
      p_all_gen_r6: assert (cout)
        else $error("R6 carry-out not set");
    end
  end

  always_comb begin
    int base;
    logic [W:0] m;
    logic [W:0] part;
    base = 0;
    for (int k = 1; k <= NBLK; k++) begin
      base = base + BLK_SZ[k-1];
      m    = {(W+1){1'b1}} >> (W + 1 - base);
      part = ({1'b0, a} & m) + ({1'b0, b} & m) + {{W{1'b0}}, cin};
      p_blk_carry_r3: assert (bc[k] == part[base])
        else $error("R3 block carry %0d mismatch", k);
    end
  end

endmodule

bind vbskip_adder vbskip_adder_chk #(.W(W), .NBLK(NBLK), .BLK_SZ(BLK_SZ)) u_chk (
  .a(a), .b(b), .cin(cin), .sum(sum), .cout(cout), .bc(bc)
);

// File: tb/test_vbskip_adder.sv
module test_vbskip_adder;
  localparam int W = 32;
  localparam int CLK_PERIOD = 10;
  localparam int NB = 7;
  localparam int SIZES [NB] = '{2, 4, 5, 6, 6, 5, 4};

  logic clk = 1'b0;
  logic [W-1:0] a = '0;
  logic [W-1:0] b = '0;
  logic cin = 1'b0;
  logic [W-1:0] sum;
  logic cout;

  int checks = 0;
  int errors = 0;
  logic [W:0] expq[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  vbskip_adder i_vbskip_adder (.a(a), .b(b), .cin(cin), .sum(sum), .cout(cout));

  task automatic check(input string req, input logic [W:0] got, input logic [W:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", req, got, exp);
    end
  endtask

  task automatic apply(input logic [W-1:0] x, input logic [W-1:0] y, input logic ci,
                       input string req);
    longint unsigned t;
    @(posedge clk);
    a = x; b = y; cin = ci;
    t = longint'(x) + longint'(y) + longint'(ci);
    expq.push_back(t[W:0]);
    @(negedge clk);
    check(req, {cout, sum}, expq.pop_front());
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int base;
    @(negedge clk);
    check("R5 initial zero", {cout, sum}, '0);

    apply('0, '0, 1'b0, "R5 zeros cin0");
    apply('0, '0, 1'b1, "R5 zeros cin1");
    apply('1, '1, 1'b0, "R6 all ones cin0");
    apply('1, '1, 1'b1, "R6 all ones cin1");
    apply('1, '0, 1'b1, "R4 full propagate cin1");
    apply('1, '0, 1'b0, "R4 full propagate cin0");
    apply(32'h1234_5678, ~32'h1234_5678, 1'b1, "R4 complement cin1");
    apply(32'h5555_5555, 32'hAAAA_AAAA, 1'b0, "R7 alternating cin0");
    apply(32'h5555_5555, 32'hAAAA_AAAA, 1'b1, "R7 alternating cin1");
    apply(32'h5555_5555, 32'h5555_5555, 1'b1, "R7 pattern5 doubled");
    apply(32'hAAAA_AAAA, 32'hAAAA_AAAA, 1'b1, "R7 patternA doubled");

    base = 0;
    for (int k = 0; k < NB; k++) begin
      logic [W-1:0] lo;
      base += SIZES[k];
      if (base < W) begin
        lo = (32'h1 << base) - 32'h1;
        apply(lo, 32'h1, 1'b0, "R3 carry reaches boundary");
        apply(lo, 32'h0, 1'b1, "R3 cin ripples to boundary");
        @(negedge clk);
        check("R3 boundary bit set", {32'h0, sum[base]}, 33'h1);
      end
    end

    for (int n = 0; n < 3000; n++) begin
      logic [W-1:0] x, y;
      x = $urandom();
      y = $urandom();
      if (n % 5 == 0) y = ~x ^ (32'h1 << (n % W));
      apply(x, y, 1'($urandom()), "R1 R2 random");
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule